// File: doc/BRIEF.md
# UART FIFO Status Flag Unit

This block tracks the fill state of a UART's transmit and receive queues and turns it into a compact status byte for the host. Each queue is represented only by an occupancy counter. The transmit counter goes up when the host writes a character and goes down when the serializer takes one. The receive counter goes up when the deserializer delivers a character and goes down when the host reads one. Data storage, shifters and baud timing are outside this block.

The status byte reports two empty indicators and two sticky error flags. Transmit-overflow records a host write into a full transmit queue. Receive-underflow records a host read from an empty receive queue. The error flags latch whatever their interrupt enables hold. Each enable only controls whether its latched flag reaches the single interrupt request. The host clears an error flag by writing a 1 to that flag's bit. The host may read or write the status byte at any time.

Top module: `uart_fifo_status_unit`

## Requirements
- R1: The status byte `stat_rdata` has this layout: bit 7 is transmit-empty, bit 6 is receive-empty, bits 5 to 2 are reserved, bit 1 is transmit-overflow and bit 0 is receive-underflow.
- R2: After a synchronous reset the status byte reads 8'hC0, both occupancies read 0 and `irq` is low.
- R3: Bit 7 is 1 exactly when the transmit occupancy is 0. A character the serializer has already taken does not count.
- R4: Bit 6 is 1 exactly when the receive occupancy is 0. A character still being assembled by the deserializer does not count.
- R5: Bits 5 to 2 always read 0. Writing 1s to them changes no bit of the status byte.
- R6: A host write (`tx_wr`) while the transmit occupancy equals DEPTH sets bit 1 on the next cycle, whatever `txovf_ie` holds. The write is discarded and the occupancy stays unchanged.
- R7: A host read (`rx_rd`) while the receive occupancy is 0 sets bit 0 on the next cycle, whatever `rxudf_ie` holds. The receive occupancy stays at 0.
- R8: A status write (`stat_wr`) with a 1 in bit 1 or bit 0 clears that error flag on the next cycle. A 0 in that bit leaves the flag unchanged.
- R9: When an error event and a write-1 clear of the same flag occur in the same cycle, the flag is 1 afterwards.
- R10: `irq` equals (bit 1 AND `txovf_ie`) OR (bit 0 AND `rxudf_ie`). It is combinational from the registered flags, so it rises in the cycle after the flag sets.
- R11: The occupancies change by accepted push minus accepted pop. A push into a full queue is not accepted, and neither is a pop from an empty queue. Each occupancy stays within 0 to DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_wr | input | 1 | Host writes a character into the transmit queue |
| tx_take | input | 1 | Serializer removes a character from the transmit queue |
| rx_put | input | 1 | Deserializer delivers a character into the receive queue |
| rx_rd | input | 1 | Host reads a character from the receive queue |
| stat_wr | input | 1 | Host write strobe for the status byte |
| stat_wdata | input | 8 | Status write data; 1 in bit 1 or bit 0 clears that flag |
| txovf_ie | input | 1 | Interrupt enable for transmit-overflow |
| rxudf_ie | input | 1 | Interrupt enable for receive-underflow |
| stat_rdata | output | 8 | Current status byte |
| irq | output | 1 | Combined interrupt request |
| tx_level | output | $clog2(DEPTH+1) | Transmit occupancy |
| rx_level | output | $clog2(DEPTH+1) | Receive occupancy |

## Verification
Two functions can fall in the same cycle. One is the event that sets an error flag: a write into a full transmit queue or a read from an empty receive queue. The other is a host write-1 clear of that same flag. The bench provokes this directly by filling the transmit queue and draining the receive queue, then issuing the error strobe and a clear of 8'hFF together. The flag is expected to read 1 afterwards, and a lone clear is then expected to drop it. Random stimulus also lands clears on error cycles at random, and every cycle is judged against a bench model in which a set overrides a clear.

// File: rtl/uart_fstat_pkg.sv
package uart_fstat_pkg;

    localparam int STAT_W    = 8;
    localparam int ERR_N     = 2;
    localparam int ERR_RXUDF = 0;
    localparam int ERR_TXOVF = 1;

    localparam logic [STAT_W-1:0] STAT_RESET = 8'hC0;
    localparam logic [STAT_W-1:0] ERR_MASK   = 8'h03;

    typedef struct packed {
        logic       tx_empty;
        logic       rx_empty;
        logic [3:0] rsvd;
        logic       tx_ovf;
        logic       rx_udf;
    } stat_byte_t;

    function automatic stat_byte_t build_status(
        input logic txe,
        input logic rxe,
        input logic [ERR_N-1:0] errs
    );
        stat_byte_t s;
        s.tx_empty = txe;
        s.rx_empty = rxe;
        s.rsvd     = '0;
        s.tx_ovf   = errs[ERR_TXOVF];
        s.rx_udf   = errs[ERR_RXUDF];
        return s;
    endfunction

endpackage

// File: rtl/fifo_occupancy.sv
module fifo_occupancy #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    output logic [CW-1:0] level,
    output logic          empty
);

    logic full;
    logic push_ok;
    logic pop_ok;

    assign empty   = (level == '0);
    assign full    = (level == CW'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= '0;
        end else if (push_ok && !pop_ok) begin
            level <= level + 1'b1;
        end else if (pop_ok && !push_ok) begin
            level <= level - 1'b1;
        end
    end

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        level <= CW'(DEPTH)) else $error("level above depth"); // R11
    AST_FULL_PUSH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (level == $past(level))) else $error("full push moved level"); // R6
    AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> (level == '0)) else $error("empty pop moved level"); // R7

endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        set |=> flag) else $error("set lost"); // R9
    AST_CLEAR_ONE: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !flag) else $error("clear ignored"); // R8
    AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!clr && !set && flag) |=> flag) else $error("flag dropped alone"); // R8

endmodule

// File: rtl/uart_fifo_status_unit.sv
module uart_fifo_status_unit
    import uart_fstat_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_wr,
    input  logic              tx_take,
    input  logic              rx_put,
    input  logic              rx_rd,
    input  logic              stat_wr,
    input  logic [STAT_W-1:0] stat_wdata,
    input  logic              txovf_ie,
    input  logic              rxudf_ie,
    output logic [STAT_W-1:0] stat_rdata,
    output logic              irq,
    output logic [CW-1:0]     tx_level,
    output logic [CW-1:0]     rx_level
);

    logic             tx_empty;
    logic             rx_empty;
    logic [ERR_N-1:0] err_set;
    logic [ERR_N-1:0] err_clr;
    logic [ERR_N-1:0] err_flag;
    logic [ERR_N-1:0] err_en;
    logic [STAT_W-1:0] clr_mask;
    stat_byte_t       status;

    fifo_occupancy #(.DEPTH(DEPTH)) u_tx_occ (
        .clk   (clk),
        .rst   (rst),
        .push  (tx_wr),
        .pop   (tx_take),
        .level (tx_level),
        .empty (tx_empty)
    );

    fifo_occupancy #(.DEPTH(DEPTH)) u_rx_occ (
        .clk   (clk),
        .rst   (rst),
        .push  (rx_put),
        .pop   (rx_rd),
        .level (rx_level),
        .empty (rx_empty)
    );

    assign clr_mask = stat_wr ? (stat_wdata & ERR_MASK) : '0;

    always_comb begin
        err_set            = '0;
        err_set[ERR_TXOVF] = tx_wr && (tx_level == CW'(DEPTH));
        err_set[ERR_RXUDF] = rx_rd && rx_empty;
        err_en             = '0;
        err_en[ERR_TXOVF]  = txovf_ie;
        err_en[ERR_RXUDF]  = rxudf_ie;
    end

    assign err_clr = clr_mask[ERR_N-1:0];

    for (genvar g = 0; g < ERR_N; g++) begin : g_err
        sticky_flag u_flag (
            .clk  (clk),
            .rst  (rst),
            .set  (err_set[g]),
            .clr  (err_clr[g]),
            .flag (err_flag[g])
        );
    end

    assign status     = build_status(tx_empty, rx_empty, err_flag);
    assign stat_rdata = status;
    assign irq        = |(err_flag & err_en);

    AST_TXE_MATCH: assert property (@(posedge clk) disable iff (rst)
        stat_rdata[7] == (tx_level == '0)) else $error("tx empty mismatch"); // R3
    AST_RXE_MATCH: assert property (@(posedge clk) disable iff (rst)
        stat_rdata[6] == (rx_level == '0)) else $error("rx empty mismatch"); // R4
    AST_OVF_IRQ_NEXT: assert property (@(posedge clk) disable iff (rst)
        (tx_wr && tx_level == CW'(DEPTH)) |=> (stat_rdata[1] && (irq || !txovf_ie))) else $error("overflow not raised"); // R10
    AST_UDF_IRQ_NEXT: assert property (@(posedge clk) disable iff (rst)
        (rx_rd && rx_level == '0) |=> (stat_rdata[0] && (irq || !rxudf_ie))) else $error("underflow not raised"); // R10
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq |-> (stat_rdata[1] || stat_rdata[0])) else $error("irq without flag"); // R10

endmodule

// File: tb/uart_fifo_status_unit_tb.sv
module uart_fifo_status_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int D          = 4;
    localparam int CW         = $clog2(D + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tx_wr = 0, tx_take = 0, rx_put = 0, rx_rd = 0, stat_wr = 0;
    logic [7:0]    stat_wdata = '0;
    logic          txovf_ie = 0, rxudf_ie = 0;
    logic [7:0]    stat_rdata;
    logic          irq;
    logic [CW-1:0] tx_level, rx_level;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    int m_tx = 0, m_rx = 0;
    bit m_ovf = 0, m_udf = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_fifo_status_unit #(.DEPTH(D)) u_dut (
        .clk(clk), .rst(rst), .tx_wr(tx_wr), .tx_take(tx_take),
        .rx_put(rx_put), .rx_rd(rx_rd), .stat_wr(stat_wr),
        .stat_wdata(stat_wdata), .txovf_ie(txovf_ie), .rxudf_ie(rxudf_ie),
        .stat_rdata(stat_rdata), .irq(irq), .tx_level(tx_level), .rx_level(rx_level)
    );

    function automatic int next_lvl(int c, bit push, bit pop);
        int pu, po;
        pu = (push && c < D) ? 1 : 0;
        po = (pop && c > 0) ? 1 : 0;
        return c + pu - po;
    endfunction

    function automatic logic [7:0] exp_stat(int t, int r, bit ovf, bit udf);
        return {(t == 0), (r == 0), 4'b0000, ovf, udf};
    endfunction

    task automatic chk(string req, int act, int expv);
        n_tests++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic check_all();
        chk("R1 status byte", stat_rdata, exp_stat(m_tx, m_rx, m_ovf, m_udf));
        chk("R10 irq", irq, (m_ovf && txovf_ie) || (m_udf && rxudf_ie));
        chk("R11 tx level", tx_level, m_tx);
        chk("R11 rx level", rx_level, m_rx);
    endtask

    task automatic step(bit tw, bit tt, bit rp, bit rr, bit sw, logic [7:0] wd);
        bit n_ovf, n_udf;
        tx_wr = tw; tx_take = tt; rx_put = rp; rx_rd = rr;
        stat_wr = sw; stat_wdata = wd;
        n_ovf = (tw && m_tx == D) || (m_ovf && !(sw && wd[1]));
        n_udf = (rr && m_rx == 0) || (m_udf && !(sw && wd[0]));
        @(posedge clk);
        #1;
        m_tx = next_lvl(m_tx, tw, tt);
        m_rx = next_lvl(m_rx, rp, rr);
        m_ovf = n_ovf;
        m_udf = n_udf;
        tx_wr = 0; tx_take = 0; rx_put = 0; rx_rd = 0; stat_wr = 0; stat_wdata = '0;
        check_all();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 100000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 17;
        void'($urandom(seed));
        repeat (2) @(posedge clk);
        #1 rst = 0;
        // R2 reset state
        chk("R2 reset status", stat_rdata, 8'hC0);
        chk("R2 reset irq", irq, 0);
        chk("R2 reset tx level", tx_level, 0);

        // R7 underflow with enable off, then irq gating R10
        step(0, 0, 0, 1, 0, 8'h00);
        chk("R7 udf set with ie=0", stat_rdata[0], 1);
        chk("R10 irq gated off", irq, 0);
        rxudf_ie = 1; #1;
        chk("R10 irq after enabling", irq, 1);
        // R8 write 0 keeps, write 1 clears
        step(0, 0, 0, 0, 1, 8'h02);
        chk("R8 write0 keeps udf", stat_rdata[0], 1);
        step(0, 0, 0, 0, 1, 8'h01);
        chk("R8 write1 clears udf", stat_rdata[0], 0);

        // fill tx queue to full, check R3
        for (int i = 0; i < D; i++) step(1, 0, 0, 0, 0, 8'h00);
        chk("R3 tx not empty when full", stat_rdata[7], 0);
        // R6 overflow, discarded write
        step(1, 0, 0, 0, 0, 8'h00);
        chk("R6 ovf flag", stat_rdata[1], 1);
        chk("R6 level unchanged", tx_level, D);
        chk("R10 irq off ovf_ie=0", irq, 0);
        // R9 set and clear same cycle
        step(1, 0, 0, 1, 1, 8'hFF);
        chk("R9 ovf survives clear", stat_rdata[1], 1);
        chk("R9 udf survives clear", stat_rdata[0], 1);
        // R5 reserved bits, writes to them
        step(0, 0, 0, 0, 1, 8'h3C);
        chk("R5 reserved read zero", stat_rdata[5:2], 0);
        chk("R5 reserved write no effect", stat_rdata, 8'h43);
        step(0, 0, 0, 0, 1, 8'hFF);
        chk("R8 clear both", stat_rdata[1:0], 0);
        // R4 receive empty tracking
        step(0, 0, 1, 0, 0, 8'h00);
        chk("R4 rx not empty", stat_rdata[6], 0);
        step(0, 0, 0, 1, 0, 8'h00);
        chk("R4 rx empty again", stat_rdata[6], 1);
        // drain tx
        for (int i = 0; i < D; i++) step(0, 1, 0, 0, 0, 8'h00);
        chk("R3 tx empty after drain", stat_rdata[7], 1);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            bit tw, tt, rp, rr, sw;
            logic [7:0] wd;
            if (($urandom % 50) == 0) begin
                txovf_ie = 1'($urandom);
                rxudf_ie = 1'($urandom);
            end
            tw = ($urandom % 100) < 45;
            tt = ($urandom % 100) < 40;
            rp = ($urandom % 100) < 40;
            rr = ($urandom % 100) < 45;
            sw = ($urandom % 100) < 15;
            wd = 8'($urandom);
            step(tw, tt, rp, rr, sw, wd);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule